// File: doc/BRIEF.md
# Synchronous Half-Duplex Serial Shifter

This block moves one byte at a time between a host and external shift-register chips over two wires. One output wire carries the shift clock. A second wire carries the data and can go either way. The host writes a byte into the transmit buffer, and the block then sends it out, least significant bit first. It produces eight clock pulses; each pulse is a high phase followed by a low phase. When the last bit has gone, it drives the data wire high and raises a transmit-complete flag.

For the other direction, the host sets a receive-enable input. The block then releases the data wire and produces eight clock pulses. On each rising edge of the clock it samples the wire, and when all eight bits are in it raises a receive-complete flag. The assembled byte is then held on a parallel output.

A shift-enable tick sets the rate, which is fixed; each tick advances one clock phase. The block works only when the two mode-select inputs are both zero. Both completion flags stay set until the host clears them.

Top module: `sync_shift_port`

## Requirements
- R1: The block acts only when mode_sel equals 2'b00. With any other value, buffer writes and receive enables are ignored: busy stays 0, sclk_o stays 1, and sd_oe stays 1.
- R2: A buffer write in mode 2'b00 while idle starts a transmission. On the next cycle busy=1, sclk_o=1, sd_oe=1 and sd_o shows bit 0 of the written byte.
- R3: A transmission makes exactly eight clock pulses. Each pulse is a high phase then a low phase, and each phase ends on a tick.
- R4: Bits leave least significant first. sd_o changes only on the edge where sclk_o goes high, so bit k is stable through the low phase of pulse k+1.
- R5: The tick that ends the eighth low phase returns the block to idle. On that same edge sclk_o=1, sd_o=1 and tx_done rises.
- R6: A reception starts when the block is idle in mode 2'b00, rx_en=1, rx_done=0 and there is no buffer write. sclk_o goes low first, and sd_oe is 0 for the whole reception. While rx_done=1, no reception starts.
- R7: Each tick that raises sclk_o during a reception samples sd_i. After eight samples rx_byte holds the byte, with the first sample in bit 0. rx_done rises and sd_oe returns to 1 on that same edge.
- R8: tx_done and rx_done stay set until clr_tx_done or clr_rx_done is high. If a flag is set and cleared in the same cycle, the set wins.
- R9: A buffer write during an active transfer is ignored. The bits, the pulse count and the end of the transfer are unchanged, and no second transfer follows.
- R10: If a buffer write and a receive start are both possible in the same idle cycle, the transmission wins: sd_oe stays 1 and the written byte is sent.
- R11: After reset sclk_o=1, sd_o=1, sd_oe=1, busy=0, tx_done=0, rx_done=0 and rx_byte=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Shift-enable; each pulse advances one clock phase |
| mode_sel | input | 2 | Mode select; the block acts only at 2'b00 |
| rx_en | input | 1 | Receive enable |
| wr_buf | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DW | Byte to transmit |
| clr_tx_done | input | 1 | Clears tx_done |
| clr_rx_done | input | 1 | Clears rx_done |
| sd_i | input | 1 | Data wire, input side |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Data wire, output side |
| sd_oe | output | 1 | Output enable for the data wire |
| busy | output | 1 | A transfer is in progress |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| rx_byte | output | DW | Last byte received |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a transfer completes on the same edge that the host holds the flag-clear input. The bench holds clr_tx_done high through a whole transmission and samples tx_done on the first cycle busy is low. tx_done must read 1 there and 0 one cycle later. In the second, a buffer write and a pending receive start meet in one idle cycle. The bench raises rx_en and wr_buf together, then expects the data wire to stay driven and the queued transmit bits to appear in order.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    mode_sel,
  input  logic          rx_en,
  input  logic          wr_buf,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_tx_done,
  input  logic          clr_rx_done,
  input  logic          sd_i,
  output logic          sclk_o,
  output logic          sd_o,
  output logic          sd_oe,
  output logic          busy,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          sclk_q, sd_q;

  wire mode_ok  = (mode_sel == 2'b00);
  wire last     = (cnt == CW'(DW-1));
  wire start_tx = mode_ok && st == S_IDLE && wr_buf;
  wire start_rx = mode_ok && st == S_IDLE && !wr_buf && rx_en && !rx_done;
  wire tx_fin   = st == S_TX && tick && !sclk_q && last;
  wire rx_fin   = st == S_RX && tick && !sclk_q && last;

  assign sclk_o = sclk_q;
  assign sd_o   = sd_q;
  assign sd_oe  = (st != S_RX);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      sclk_q  <= 1'b1;
      sd_q    <= 1'b1;
      rx_byte <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_tx) begin
            st     <= S_TX;
            sh     <= wr_data;
            sd_q   <= wr_data[0];
            cnt    <= '0;
            sclk_q <= 1'b1;
          end else if (start_rx) begin
            st     <= S_RX;
            cnt    <= '0;
            sclk_q <= 1'b0;
          end
        end
        S_TX: begin
          if (tick) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else begin
              sclk_q <= 1'b1;
              if (last) begin
                sd_q <= 1'b1;
                st   <= S_IDLE;
              end else begin
                cnt  <= cnt + 1'b1;
                sd_q <= sh[1];
                sh   <= sh >> 1;
              end
            end
          end
        end
        S_RX: begin
          if (tick) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else begin
              sclk_q <= 1'b1;
              sh     <= {sd_i, sh[DW-1:1]};
              if (last) begin
                rx_byte <= {sd_i, sh[DW-1:1]};
                st      <= S_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (tx_fin)           tx_done <= 1'b1;
      else if (clr_tx_done) tx_done <= 1'b0;
      if (rx_fin)           rx_done <= 1'b1;
      else if (clr_rx_done) rx_done <= 1'b0;
    end
  end

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_sel != 2'b00) |=> !busy); // R1
  AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> sclk_o); // R4
  AST_TX_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (sclk_o && sd_o && sd_oe && !busy)); // R5
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !busy) |=> sd_oe); // R6
  AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_tx_done) |=> tx_done); // R8
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_rx_done) |=> rx_done); // R8
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o && sd_oe)); // R11
endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic rx_en = 1'b0, wr_buf = 1'b0, clr_tx_done = 1'b0, clr_rx_done = 1'b0, sd_i = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic sclk_o, sd_o, sd_oe, busy, tx_done, rx_done;
  logic [DW-1:0] rx_byte;

  int checks = 0, errors = 0, pulses = 0, ridx = 0, tcnt = 0;
  bit finished = 0;
  logic prev_sclk = 1'b1;
  logic [DW-1:0] rx_pat = '0;
  bit exp_q[$];

  sync_shift_port #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .rx_en(rx_en),
    .wr_buf(wr_buf), .wr_data(wr_data), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .sd_i(sd_i), .sclk_o(sclk_o), .sd_o(sd_o),
    .sd_oe(sd_oe), .busy(busy), .tx_done(tx_done), .rx_done(rx_done),
    .rx_byte(rx_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt == 2) ? 0 : tcnt + 1;
    tick = (tcnt == 2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for transmitted bits, plus external slave for receive
  always @(negedge clk) begin
    if (rst_n && prev_sclk && !sclk_o && sd_oe) begin
      pulses++;
      if (exp_q.size() == 0) chk(0, "R3 extra pulse", pulses, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(sd_o === e, "R4 bit", int'(sd_o), int'(e));
      end
    end
    if (rst_n && !prev_sclk && sclk_o && !sd_oe) begin
      ridx++;
      if (ridx < DW) sd_i = rx_pat[ridx];
    end
    prev_sclk = sclk_o;
  end

  task automatic push_byte(input logic [DW-1:0] d);
    for (int i = 0; i < DW; i++) exp_q.push_back(d[i]);
  endtask

  task automatic write_buf(input logic [DW-1:0] d);
    @(negedge clk); wr_buf = 1'b1; wr_data = d;
    @(negedge clk); wr_buf = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input string req);
    int p0;
    p0 = pulses;
    push_byte(d);
    write_buf(d);
    chk(busy && sclk_o && sd_oe && sd_o == d[0], "R2 start", int'({busy, sclk_o, sd_oe, sd_o}), 4'hF - {3'b0, ~d[0]});
    wait_idle();
    chk(tx_done && sclk_o && sd_o, {req, " R5 end"}, int'({tx_done, sclk_o, sd_o}), 7);
    chk(pulses - p0 == DW && exp_q.size() == 0, "R3 pulse count", pulses - p0, DW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({sclk_o, sd_o, sd_oe, busy, tx_done, rx_done} == 6'b111000 && rx_byte == 0,
        "R11 reset", int'({sclk_o, sd_o, sd_oe, busy, tx_done, rx_done}), 6'b111000);

    send(8'hA5, "R4");
    repeat (6) @(negedge clk);
    chk(tx_done, "R8 sticky tx", tx_done, 1);
    clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;
    chk(!tx_done, "R8 clear tx", tx_done, 0);

    send(8'h01, "R3");
    clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;

    // R1 other modes ignored
    begin
      int p0;
      p0 = pulses;
      mode_sel = 2'b01;
      write_buf(8'h55);
      rx_en = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (busy || !sd_oe) break;
      end
      rx_en = 1'b0;
      chk(!busy && sd_oe && sclk_o && pulses == p0, "R1 mode gate", int'({busy, sd_oe, sclk_o}), 3'b011);
      mode_sel = 2'b11;
      write_buf(8'hFF);
      repeat (10) @(negedge clk);
      chk(!busy && pulses == p0, "R1 mode 11", busy, 0);
      mode_sel = 2'b00;
    end

    // R9 write during transfer ignored
    begin
      int p0;
      p0 = pulses;
      push_byte(8'h3C);
      write_buf(8'h3C);
      repeat (9) @(negedge clk);
      write_buf(8'hFF);
      wait_idle();
      repeat (12) @(negedge clk);
      chk(!busy && pulses - p0 == DW && exp_q.size() == 0, "R9 ignored write", pulses - p0, DW);
      clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;
    end

    // R8 set and clear in the same cycle: set wins
    clr_tx_done = 1'b1;
    push_byte(8'hC3);
    write_buf(8'hC3);
    wait_idle();
    chk(tx_done, "R8 set beats clear", tx_done, 1);
    @(negedge clk);
    chk(!tx_done, "R8 clear next", tx_done, 0);
    clr_tx_done = 1'b0;

    // R6 / R7 reception
    rx_pat = 8'h5A; ridx = 0; sd_i = rx_pat[0];
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); rx_en = 1'b0;
    chk(!sd_oe && !sclk_o && busy, "R6 rx start", int'({sd_oe, sclk_o, busy}), 3'b001);
    while (!rx_done) begin
      @(negedge clk);
      if (busy) chk(!sd_oe, "R6 oe released", sd_oe, 0);
    end
    chk(rx_byte == 8'h5A && sd_oe && sclk_o, "R7 rx byte", rx_byte, 8'h5A);
    // R6 no reception while rx_done set
    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(sd_oe && !busy && rx_done, "R6 blocked by flag", int'({sd_oe, busy, rx_done}), 3'b101);
    rx_en = 1'b0;
    clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;
    chk(!rx_done, "R8 clear rx", rx_done, 0);

    rx_pat = 8'h81; ridx = 0; sd_i = rx_pat[0];
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); rx_en = 1'b0;
    while (!rx_done) @(negedge clk);
    chk(rx_byte == 8'h81, "R7 rx byte 2", rx_byte, 8'h81);
    clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;

    // R10 write and receive start together: transmit wins
    push_byte(8'h6E);
    @(negedge clk); rx_en = 1'b1; wr_buf = 1'b1; wr_data = 8'h6E;
    @(negedge clk); rx_en = 1'b0; wr_buf = 1'b0;
    chk(busy && sd_oe && sclk_o && sd_o == 1'b0, "R10 tx wins", int'({busy, sd_oe, sclk_o, sd_o}), 4'b1110);
    wait_idle();
    chk(tx_done && exp_q.size() == 0 && !rx_done, "R10 tx done", int'({tx_done, rx_done}), 2'b10);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule